// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block collects up to 32 hardware event pulses into sticky cause bits. Software reaches it through a plain register port with separate write and read strobes, a byte address and a data word. Each bit can be acknowledged in one of two ways, chosen per bit at run time. In write-one-to-clear mode, software writes ones to the bits it has handled. In clear-on-read mode, reading a bit removes it.

A mask register decides which causes reach the single level-sensitive interrupt line. The mask is never written as a whole word. One strobe address sets mask bits and another clears them, so software can change one group of sources without touching the others. A masked view lets software read only the causes that are currently enabled. Another address returns the mask without any side effect.

Register word offsets, byte addressed: raw cause 0x0, masked cause 0x4, clear mode 0x8, mask set 0xC, mask clear 0x10, mask value 0x14. Address bits below bit 2 are ignored. Other offsets read as zero and ignore writes.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1, every clear-mode bit is 0 (write-one-to-clear), and irqOut is 0.
- R2: An event pulse on bit i sets cause bit i at the next clock edge, and the bit stays set until a clear action in its mode removes it.
- R3: For a bit in write-one-to-clear mode (mode bit 0), writing offset 0x0 clears the bit when the written value has a 1 in that position. Writing 0 there, or reading any offset, leaves the bit as it is.
- R4: For a bit in clear-on-read mode (mode bit 1), a read of offset 0x0 returns the bit and then clears it. A write of 1 to that position at offset 0x0 has no effect.
- R5: A read of offset 0x4 returns cause AND NOT mask. For clear-on-read bits, this read clears only the bits it returned, so masked bits stay set.
- R6: Offset 0x8 holds one clear-mode bit per cause bit (1 = clear-on-read). It is written as a whole word, reads back the stored value, and mixed patterns give per-bit behaviour.
- R7: Writing offset 0xC sets the mask bits where the written value is 1 and leaves the others unchanged. Reading 0xC returns 0.
- R8: Writing offset 0x10 clears the mask bits where the written value is 1 and leaves the others unchanged. Reading 0x10 returns 0.
- R9: Reading offset 0x14 returns the current mask and changes neither the mask nor any cause bit.
- R10: An event pulse in the same cycle as a clear of that bit (by write or by read) wins, and the bit stays set.
- R11: irqOut is 1 exactly when some cause bit is set whose mask bit is 0. It follows register changes in the cycle after the edge that updates them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | NUM_BITS | One-cycle event pulses, one per cause bit |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; clear-on-read effects apply at the clock edge that ends the read cycle |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | NUM_BITS | Write data |
| rdData | output | NUM_BITS | Read data, valid in the same cycle as rdEn |
| irqOut | output | 1 | Level interrupt: OR of the unmasked causes |

## Verification
A wrong internal state shows up at the ports within one cycle.

- **Mask:** a bit stuck in the mask register changes both irqOut and the value read at 0x14 on the next cycle.
- **Clear mode:** a wrong clear-mode bit shows on the second of two back-to-back reads of 0x0. A bit that should have been removed is still there, or one that should have survived is gone.
- **Event versus clear:** a lost event or a wrong priority between event and clear shows as a missing bit on the very next read.

The test sequence therefore pairs every clear action with an immediate readback, and checks irqOut after each mask change.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

  // Read selection, encoded as the word index of each register.
  typedef enum logic [2:0] {
    SEL_CAUSE   = 3'd0,
    SEL_MASKED  = 3'd1,
    SEL_MODE    = 3'd2,
    SEL_SET     = 3'd3,
    SEL_CLR     = 3'd4,
    SEL_MASKVAL = 3'd5,
    SEL_NONE    = 3'd7
  } regSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic    wrCause;
    logic    wrMode;
    logic    setMask;
    logic    clrMask;
    logic    rdCause;
    logic    rdMasked;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrobes_t      strb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  assign wordIdx = addr[ADDR_W-1:2];

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    case (wordIdx)
      IDX_W'(0): begin
        strb.rdSel   = SEL_CAUSE;
        strb.wrCause = wrEn;
        strb.rdCause = rdEn;
      end
      IDX_W'(1): begin
        strb.rdSel    = SEL_MASKED;
        strb.rdMasked = rdEn;
      end
      IDX_W'(2): begin
        strb.rdSel  = SEL_MODE;
        strb.wrMode = wrEn;
      end
      IDX_W'(3): begin
        strb.rdSel   = SEL_SET;
        strb.setMask = wrEn;
      end
      IDX_W'(4): begin
        strb.rdSel   = SEL_CLR;
        strb.clrMask = wrEn;
      end
      IDX_W'(5): strb.rdSel = SEL_MASKVAL;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_cause_dp.sv
module irq_cause_dp
  import irq_cause_pkg::*;
#(
  parameter int NUM_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_BITS-1:0] evtPulse,
  input  logic [NUM_BITS-1:0] wrData,
  input  ctrlStrobes_t        strb,
  output logic [NUM_BITS-1:0] rdData,
  output logic                irqOut,
  output logic [NUM_BITS-1:0] causeQ,
  output logic [NUM_BITS-1:0] maskQ
);
  logic [NUM_BITS-1:0] modeQ;
  logic [NUM_BITS-1:0] clrVec;
  logic [NUM_BITS-1:0] maskSetVec;
  logic [NUM_BITS-1:0] maskClrVec;
  logic [NUM_BITS-1:0] maskedView;

  assign maskedView = causeQ & ~maskQ;

  // Clear sources: a write clears write-one-to-clear bits;
  // a read clears clear-on-read bits that the read returned.
  always_comb begin
    clrVec = '0;
    if (strb.wrCause)  clrVec = clrVec | (wrData & ~modeQ);
    if (strb.rdCause)  clrVec = clrVec | (causeQ & modeQ);
    if (strb.rdMasked) clrVec = clrVec | (maskedView & modeQ);
  end

  // One sticky cell per cause bit; an event beats a clear.
  for (genvar i = 0; i < NUM_BITS; i++) begin : gCause
    always_ff @(posedge clk) begin
      if (!rstN) causeQ[i] <= 1'b0;
      else       causeQ[i] <= evtPulse[i] | (causeQ[i] & ~clrVec[i]);
    end
  end

  assign maskSetVec = strb.setMask ? wrData : '0;
  assign maskClrVec = strb.clrMask ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ <= '1;
      modeQ <= '0;
    end else begin
      maskQ <= (maskQ | maskSetVec) & ~maskClrVec;
      if (strb.wrMode) modeQ <= wrData;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_CAUSE:   rdData = causeQ;
      SEL_MASKED:  rdData = maskedView;
      SEL_MODE:    rdData = modeQ;
      SEL_MASKVAL: rdData = maskQ;
      default:     rdData = '0;
    endcase
  end

  assign irqOut = |maskedView;
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
  import irq_cause_pkg::*;
#(
  parameter int NUM_BITS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_BITS-1:0] evtPulse,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_BITS-1:0] wrData,
  output logic [NUM_BITS-1:0] rdData,
  output logic                irqOut
);
  ctrlStrobes_t        strb;
  logic [NUM_BITS-1:0] causeQ;
  logic [NUM_BITS-1:0] maskQ;

  irq_cause_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  irq_cause_dp #(.NUM_BITS(NUM_BITS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .evtPulse (evtPulse),
    .wrData   (wrData),
    .strb     (strb),
    .rdData   (rdData),
    .irqOut   (irqOut),
    .causeQ   (causeQ),
    .maskQ    (maskQ)
  );
endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
  parameter int NUM_BITS = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_BITS-1:0] evtPulse,
  input logic                wrEn,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_BITS-1:0] wrData,
  input logic [NUM_BITS-1:0] rdData,
  input logic                irqOut,
  input logic [NUM_BITS-1:0] causeQ,
  input logic [NUM_BITS-1:0] maskQ
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:2];

  AST_RESET_MASKED: assert property (@(posedge clk)
    $rose(rstN) |-> (maskQ == '1) && !irqOut); // R1

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((causeQ & $past(evtPulse)) == $past(evtPulse))); // R10

  AST_MASKED_READ_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && idx == IDX_W'(1) && rdData != '0) |-> irqOut); // R11

  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && (idx == IDX_W'(3) || idx == IDX_W'(4))) |-> (rdData == '0)); // R7

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(3)) |=> ((maskQ & $past(wrData)) == $past(wrData))); // R7

  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && idx == IDX_W'(4)) |=> ((maskQ & $past(wrData)) == '0)); // R8

  AST_MASKVAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && idx == IDX_W'(5)) |=>
      ($stable(maskQ) && (($past(causeQ) & ~causeQ) == '0))); // R9
endmodule

bind irq_cause_bank irq_cause_bank_chk #(.NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .evtPulse (evtPulse),
  .wrEn     (wrEn),
  .rdEn     (rdEn),
  .addr     (addr),
  .wrData   (wrData),
  .rdData   (rdData),
  .irqOut   (irqOut),
  .causeQ   (causeQ),
  .maskQ    (maskQ)
);

// File: tb/sim_irq_cause_bank.sv
module sim_irq_cause_bank;
  localparam int NB = 32;
  localparam int AW = 5;

  typedef struct {
    logic [NB-1:0] val;
    string         tag;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] evtPulse = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NB-1:0] wrData = '0;
  logic [NB-1:0] rdData;
  logic          irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expItem_t expQ[$];

  always #2 clk = ~clk;

  irq_cause_bank #(.NUM_BITS(NB), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // Monitor: pops one expected item per read cycle, mid-cycle.
  always @(negedge clk) begin
    if (rdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: got %h expected none", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.val) begin
          errors++;
          $display("FAIL %s: rdData got %h expected %h", it.tag, rdData, it.val);
        end
      end
    end
  end

  // Driver: one bus cycle, optionally with an event pulse in the same cycle.
  task automatic busCycle(input bit w, input bit r, input logic [AW-1:0] a,
                          input logic [NB-1:0] d, input logic [NB-1:0] evt);
    @(posedge clk); #1;
    wrEn = w; rdEn = r; addr = a; wrData = d; evtPulse = evt;
    @(posedge clk); #1;
    wrEn = 1'b0; rdEn = 1'b0; evtPulse = '0; wrData = '0;
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [NB-1:0] d);
    busCycle(1'b1, 1'b0, a, d, '0);
  endtask

  task automatic busRead(input logic [AW-1:0] a, input logic [NB-1:0] e, input string tag);
    expItem_t it;
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    busCycle(1'b0, 1'b1, a, '0, '0);
  endtask

  task automatic pulse(input logic [NB-1:0] evt);
    busCycle(1'b0, 1'b0, '0, '0, evt);
  endtask

  task automatic checkIrq(input logic e, input string tag);
    @(negedge clk);
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s: irqOut got %b expected %b", tag, irqOut, e);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1 irq after reset");
    busRead(5'h14, 32'hFFFF_FFFF, "R1 mask after reset");
    busRead(5'h00, 32'h0, "R1 cause after reset");
    busRead(5'h08, 32'h0, "R1 mode after reset");

    // R2 sticky set; R3 reads do not clear write-one-to-clear bits
    pulse(32'h0000_00A5);
    busRead(5'h00, 32'h0000_00A5, "R2 event sets cause");
    busRead(5'h00, 32'h0000_00A5, "R3 read leaves W1C bits");
    checkIrq(1'b0, "R11 all masked");

    // R8 mask clear, R5 masked view, R11 irq
    busWrite(5'h10, 32'h0000_000F);
    busRead(5'h14, 32'hFFFF_FFF0, "R8 mask clear");
    checkIrq(1'b1, "R11 unmasked cause");
    busRead(5'h04, 32'h0000_0005, "R5 masked view");
    busRead(5'h10, 32'h0, "R8 clear reg reads zero");
    busRead(5'h0C, 32'h0, "R7 set reg reads zero");

    // R3 write-one-to-clear
    busWrite(5'h00, 32'h0000_0004);
    busRead(5'h00, 32'h0000_00A1, "R3 clear exact bit");
    busWrite(5'h00, 32'h0000_0001);
    checkIrq(1'b0, "R11 no unmasked cause");
    busRead(5'h04, 32'h0, "R5 masked view empty");

    // R7 mask set
    busWrite(5'h0C, 32'h0000_0003);
    busRead(5'h14, 32'hFFFF_FFF3, "R7 mask set");

    // R6 all clear-on-read; R5 masked read clears only returned bits
    busWrite(5'h08, 32'hFFFF_FFFF);
    busRead(5'h08, 32'hFFFF_FFFF, "R6 mode readback");
    pulse(32'h0000_000C);
    busRead(5'h04, 32'h0000_000C, "R5 masked COR read");
    busRead(5'h00, 32'h0000_00A0, "R5 masked bits kept");
    busRead(5'h00, 32'h0, "R4 COR cleared by read");
    pulse(32'h0000_0030);
    busWrite(5'h00, 32'h0000_00FF);
    busRead(5'h00, 32'h0000_0030, "R4 write ignored in COR");
    busRead(5'h00, 32'h0, "R4 cleared after read");

    // R6 mixed per-bit modes
    busWrite(5'h08, 32'h0000_00F0);
    pulse(32'h0000_00FF);
    busRead(5'h00, 32'h0000_00FF, "R6 mixed read");
    busRead(5'h00, 32'h0000_000F, "R6 only COR bits cleared");
    busWrite(5'h00, 32'h0000_000F);
    busRead(5'h00, 32'h0, "R6 W1C bits cleared by write");

    // R10 event beats clear (write clear and read clear)
    pulse(32'h0000_0001);
    busCycle(1'b1, 1'b0, 5'h00, 32'h0000_0001, 32'h0000_0001);
    busRead(5'h00, 32'h0000_0001, "R10 event beats write clear");
    pulse(32'h0000_0010);
    begin
      expItem_t it;
      it.val = 32'h0000_0011; it.tag = "R10 read during event";
      expQ.push_back(it);
    end
    busCycle(1'b0, 1'b1, 5'h00, '0, 32'h0000_0010);
    busRead(5'h00, 32'h0000_0011, "R10 event beats read clear");
    busRead(5'h00, 32'h0000_0001, "R10 then cleared");

    // R9 mask value read has no side effect
    busRead(5'h14, 32'hFFFF_FFF3, "R9 mask read");
    busRead(5'h14, 32'hFFFF_FFF3, "R9 mask read repeat");
    busRead(5'h00, 32'h0000_0001, "R9 cause unchanged");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d reads missing, expected 0", expQ.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule